// File: doc/BRIEF.md
# Programmable Read Traffic Generator

This block is a synthesizable read-only bus master that stands in for a real client when an interconnect or a memory subsystem has to be loaded with realistic traffic. After reset it stays silent for a programmed number of cycles. It then issues incrementing read bursts on the read address channel. Each burst has a fixed, programmed beat count, and every beat is one full 64-byte data word. It keeps issuing until a programmed byte budget has been requested. After that it stalls for good and, once every burst has returned its last beat, raises `done`.

Each burst start address is drawn at random from one of two windows. A pseudo-random value, reduced modulo 100, is compared with a percentage weight to pick the window, so a 40/60 split between the windows is obtained by programming 40. Three independent throttles shape the traffic:
- a minimum number of idle cycles after each accepted request;
- a byte-credit bucket that refills by a programmed amount every cycle and caps the average issue bandwidth;
- a programmable ceiling on the number of bursts in flight.

A ceiling of one makes the throughput depend only on the round-trip latency. Read data is drained and discarded. Only the response code of each beat is inspected.

The configuration inputs are held steady from the start of reset until the run finishes.

Top module: `rdgen_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `arvalid`, `done` and `err` are 0 and `rready` is 1.
- R2: No request appears until more than `cfg_start_delay` clock cycles have elapsed since reset was released.
- R3: Every request uses `arsize` = 3'b110 (64-byte beats), `arburst` = 2'b01 (incrementing) and `arlen` = `cfg_len` (beats minus one, 0..63), with `araddr[5:0]` = 0. A request that is not yet accepted keeps `arvalid` high and its address and length unchanged.
- R4: Window 0 is [`cfg_base0`, `cfg_base0` + 2^`cfg_k0`) and window 1 is [`cfg_base1`, `cfg_base1` + 2^`cfg_k1`). Each base is aligned to its window size, and 12 <= k < address width. Every address lies in a window. A weight `cfg_w0` of 100 selects only window 0, a weight of 0 selects only window 1, and a weight in between makes both windows appear.
- R5: No burst crosses a 4096-byte boundary: `araddr[11:0]` + (`arlen`+1)*64 <= 4096.
- R6: The total requested equals `cfg_total_bytes` rounded up to a whole number of bursts, and all of those beats are accepted. With a budget of 0, no request is made. After the budget is spent, no further request is ever made.
- R7: After a request is accepted, `arvalid` stays low for at least `cfg_gap` cycles before the next request.
- R8: The credit bucket starts empty at reset, gains `cfg_bw_inc` bytes per cycle, and is charged the size of each burst it issues. As a result, the bytes requested up to cycle n since reset never exceed n*`cfg_bw_inc`.
- R9: The number of bursts requested but not yet completed by a last beat never exceeds `cfg_max_out` (valid range 1..MAX_OUT).
- R10: `done` rises only when the budget is spent and every burst has returned its last beat. It then stays high until reset.
- R11: `err` becomes 1 after any accepted beat whose `rresp` is not 2'b00 and stays 1 until reset. A run with only 2'b00 responses leaves it 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_start_delay | input | 16 | Silent cycles after reset |
| cfg_total_bytes | input | 32 | Byte budget for the run |
| cfg_len | input | 6 | Beats per burst minus one |
| cfg_gap | input | 8 | Minimum idle cycles after an accepted request |
| cfg_bw_inc | input | 13 | Credit bytes added per cycle |
| cfg_w0 | input | 7 | Percentage weight of window 0 (0..100) |
| cfg_base0 | input | 32 | Base address of window 0 |
| cfg_k0 | input | 5 | log2 of window 0 size |
| cfg_base1 | input | 32 | Base address of window 1 |
| cfg_k1 | input | 5 | log2 of window 1 size |
| cfg_max_out | input | 3 | Ceiling on bursts in flight |
| arvalid | output | 1 | Read request valid |
| arready | input | 1 | Read request accepted |
| araddr | output | 32 | Burst start address |
| arlen | output | 8 | Beats minus one |
| arsize | output | 3 | Beat size code |
| arburst | output | 2 | Burst type |
| rvalid | input | 1 | Read beat valid |
| rready | output | 1 | Always ready for read beats |
| rresp | input | 2 | Beat response code |
| rlast | input | 1 | Last beat of a burst |
| done | output | 1 | Budget spent and all bursts completed |
| err | output | 1 | Sticky error-response flag |

## Verification
The bench targets the following corner cases:
- A budget that is not a multiple of the burst size. A design that truncates instead of rounding up would request one burst too few.
- A budget of zero. A design that checks the budget only after issuing would send one stray burst.
- 64-beat bursts, which must start exactly on a 4096-byte page. A wrong page clamp would cross the boundary or leave the window.
- The weight extremes of 0 and 100, where one off-by-one in the comparison would let a single request land in the wrong window.
- An in-flight ceiling of one against a slave that stalls its responses. A design that counts in-flight bursts only at acceptance would have two outstanding.
- An error response in the middle of a burst, which must set a flag that later good responses do not clear.

// File: rtl/rdgen_pkg.sv
package rdgen_pkg;

    // Incrementing burst code and the all-good response code on the read channel.
    localparam logic [1:0] BURST_INCR = 2'b01;
    localparam logic [1:0] RESP_OKAY  = 2'b00;

    // A burst must stay within one page of this size.
    localparam int PAGE_LOG2 = 12;

    typedef enum logic [0:0] {
        ST_SILENT = 1'b0,
        ST_ISSUE  = 1'b1
    } gen_state_e;

    // Outcome of the window draw for one burst.
    typedef struct packed {
        logic        win1;
        logic [31:0] addr;
    } pick_t;

    // Pull an in-page offset back so that a burst of nbytes ends on or before the page end.
    function automatic logic [PAGE_LOG2-1:0] page_fit(
        input logic [PAGE_LOG2-1:0] off,
        input logic [PAGE_LOG2:0]   nbytes
    );
        logic [PAGE_LOG2+1:0] stop;
        logic [PAGE_LOG2:0]   page;
        page = (PAGE_LOG2+1)'(1) << PAGE_LOG2;
        stop = {2'b00, off} + {1'b0, nbytes};
        if (stop > {1'b0, page})
            return PAGE_LOG2'(page - nbytes);
        return off;
    endfunction

endpackage

// File: rtl/rdgen_lfsr.sv
module rdgen_lfsr #(
    parameter int          W     = 32,
    parameter logic [W-1:0] TAPS = 32'h8020_0003,
    parameter logic [W-1:0] SEED = 32'hACE1_2468
) (
    input  logic         clk,
    input  logic         rst,
    output logic [W-1:0] value
);
    // Galois form, shifting right: one step per cycle.
    always_ff @(posedge clk) begin
        if (rst)
            value <= SEED;
        else if (value[0])
            value <= (value >> 1) ^ TAPS;
        else
            value <= value >> 1;
    end
endmodule

// File: rtl/rdgen_addr_pick.sv
module rdgen_addr_pick
    import rdgen_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int RND_W     = 32,
    parameter int K_W       = 5,
    parameter int BEAT_LOG2 = 6,
    parameter int BYTES_W   = 13
) (
    input  logic [RND_W-1:0]   rnd,
    input  logic [6:0]         w0,
    input  logic [ADDR_W-1:0]  base0,
    input  logic [K_W-1:0]     k0,
    input  logic [ADDR_W-1:0]  base1,
    input  logic [K_W-1:0]     k1,
    input  logic [BYTES_W-1:0] nbytes,
    output pick_t              pick
);
    localparam int HALF = RND_W / 2;

    logic [HALF-1:0]        draw;
    logic [6:0]             pct;
    logic                   use1;
    logic [K_W-1:0]         k_sel;
    logic [ADDR_W-1:0]      base_sel;
    logic [ADDR_W-1:0]      mask;
    logic [ADDR_W-1:0]      raw;
    logic [PAGE_LOG2-1:0]   low;

    always_comb begin
        // Upper half of the random word picks the window, lower bits the offset.
        draw     = rnd[RND_W-1 -: HALF];
        pct      = 7'(draw % HALF'(100));
        use1     = (pct >= w0);
        k_sel    = use1 ? k1 : k0;
        base_sel = use1 ? base1 : base0;
        mask     = (ADDR_W'(1) << k_sel) - ADDR_W'(1);
        raw      = (ADDR_W'(rnd) << BEAT_LOG2) & mask;
        low      = page_fit(raw[PAGE_LOG2-1:0], (PAGE_LOG2+1)'(nbytes));
        pick.win1 = use1;
        pick.addr = 32'(base_sel | {raw[ADDR_W-1:PAGE_LOG2], low});
    end
endmodule

// File: rtl/rdgen_rate.sv
module rdgen_rate #(
    parameter int INC_W   = 13,
    parameter int GAP_W   = 8,
    parameter int BYTES_W = 13,
    parameter int BKT_W   = 17
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [INC_W-1:0]   inc,
    input  logic [GAP_W-1:0]   gap,
    input  logic               take,
    input  logic [BYTES_W-1:0] need,
    input  logic               accept,
    output logic               ok
);
    localparam logic [BKT_W:0] BKT_MAX = {1'b0, {BKT_W{1'b1}}};

    logic [BKT_W-1:0] bucket;
    logic [BKT_W-1:0] after_take;
    logic [BKT_W:0]   sum;
    logic [GAP_W-1:0] gap_cnt;

    always_comb begin
        after_take = bucket - (take ? BKT_W'(need) : '0);
        sum        = {1'b0, after_take} + (BKT_W+1)'(inc);
        ok         = (gap_cnt == '0) && (bucket >= BKT_W'(need));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bucket  <= '0;
            gap_cnt <= '0;
        end else begin
            bucket <= (sum > BKT_MAX) ? BKT_MAX[BKT_W-1:0] : sum[BKT_W-1:0];
            if (accept)
                gap_cnt <= gap;
            else if (gap_cnt != '0)
                gap_cnt <= gap_cnt - 1'b1;
        end
    end
endmodule

// File: rtl/rdgen_top.sv
module rdgen_top
    import rdgen_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int BEAT_BYTES = 64,
    parameter int LEN_CFG_W  = 6,
    parameter int DLY_W      = 16,
    parameter int TOT_W      = 32,
    parameter int GAP_W      = 8,
    parameter int INC_W      = 13,
    parameter int K_W        = 5,
    parameter int MAX_OUT    = 4,
    parameter int BKT_W      = 17,
    parameter int OUT_W      = $clog2(MAX_OUT + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [DLY_W-1:0]     cfg_start_delay,
    input  logic [TOT_W-1:0]     cfg_total_bytes,
    input  logic [LEN_CFG_W-1:0] cfg_len,
    input  logic [GAP_W-1:0]     cfg_gap,
    input  logic [INC_W-1:0]     cfg_bw_inc,
    input  logic [6:0]           cfg_w0,
    input  logic [ADDR_W-1:0]    cfg_base0,
    input  logic [K_W-1:0]       cfg_k0,
    input  logic [ADDR_W-1:0]    cfg_base1,
    input  logic [K_W-1:0]       cfg_k1,
    input  logic [OUT_W-1:0]     cfg_max_out,
    output logic                 arvalid,
    input  logic                 arready,
    output logic [ADDR_W-1:0]    araddr,
    output logic [7:0]           arlen,
    output logic [2:0]           arsize,
    output logic [1:0]           arburst,
    input  logic                 rvalid,
    output logic                 rready,
    input  logic [1:0]           rresp,
    input  logic                 rlast,
    output logic                 done,
    output logic                 err
);
    localparam int BEAT_LOG2 = $clog2(BEAT_BYTES);
    localparam int BYTES_W   = BEAT_LOG2 + LEN_CFG_W + 1;
    localparam int RND_W     = 32;

    gen_state_e         state;
    logic [DLY_W-1:0]   dly_cnt;
    logic [TOT_W:0]     issued;
    logic [OUT_W-1:0]   out_cnt;
    logic [BYTES_W-1:0] burst_bytes;
    logic [RND_W-1:0]   rnd;
    pick_t              pick;
    logic               rate_ok;
    logic               budget_left;
    logic               launch;
    logic               ar_hs;
    logic               r_end;

    assign arsize  = 3'(BEAT_LOG2);
    assign arburst = BURST_INCR;
    assign rready  = 1'b1;

    always_comb begin
        burst_bytes = (BYTES_W'(cfg_len) + BYTES_W'(1)) << BEAT_LOG2;
        budget_left = issued < {1'b0, cfg_total_bytes};
        ar_hs       = arvalid && arready;
        r_end       = rvalid && rlast;
        launch      = (state == ST_ISSUE) && !arvalid && budget_left &&
                      (out_cnt < cfg_max_out) && rate_ok;
    end

    rdgen_lfsr #(.W(RND_W)) u_lfsr (
        .clk   (clk),
        .rst   (rst),
        .value (rnd)
    );

    rdgen_addr_pick #(
        .ADDR_W    (ADDR_W),
        .RND_W     (RND_W),
        .K_W       (K_W),
        .BEAT_LOG2 (BEAT_LOG2),
        .BYTES_W   (BYTES_W)
    ) u_pick (
        .rnd    (rnd),
        .w0     (cfg_w0),
        .base0  (cfg_base0),
        .k0     (cfg_k0),
        .base1  (cfg_base1),
        .k1     (cfg_k1),
        .nbytes (burst_bytes),
        .pick   (pick)
    );

    rdgen_rate #(
        .INC_W   (INC_W),
        .GAP_W   (GAP_W),
        .BYTES_W (BYTES_W),
        .BKT_W   (BKT_W)
    ) u_rate (
        .clk    (clk),
        .rst    (rst),
        .inc    (cfg_bw_inc),
        .gap    (cfg_gap),
        .take   (launch),
        .need   (burst_bytes),
        .accept (ar_hs),
        .ok     (rate_ok)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_SILENT;
            dly_cnt <= '0;
            arvalid <= 1'b0;
            araddr  <= '0;
            arlen   <= '0;
            issued  <= '0;
            out_cnt <= '0;
            done    <= 1'b0;
            err     <= 1'b0;
        end else begin
            if (state == ST_SILENT) begin
                if (dly_cnt >= cfg_start_delay)
                    state <= ST_ISSUE;
                else
                    dly_cnt <= dly_cnt + 1'b1;
            end

            if (launch) begin
                arvalid <= 1'b1;
                araddr  <= ADDR_W'(pick.addr);
                arlen   <= 8'(cfg_len);
                issued  <= issued + (TOT_W+1)'(burst_bytes);
            end else if (ar_hs) begin
                arvalid <= 1'b0;
            end

            out_cnt <= out_cnt + OUT_W'(launch) - OUT_W'(r_end);

            if (rvalid && (rresp != RESP_OKAY))
                err <= 1'b1;

            if ((state == ST_ISSUE) && !budget_left && (out_cnt == '0) && !arvalid)
                done <= 1'b1;
        end
    end
endmodule

// File: rtl/rdgen_chk.sv
module rdgen_chk #(
    parameter int ADDR_W = 32,
    parameter int DLY_W  = 16,
    parameter int OUT_W  = 3
) (
    input logic              clk,
    input logic              rst,
    input logic [DLY_W-1:0]  cfg_start_delay,
    input logic [OUT_W-1:0]  cfg_max_out,
    input logic              arvalid,
    input logic              arready,
    input logic [ADDR_W-1:0] araddr,
    input logic [7:0]        arlen,
    input logic [2:0]        arsize,
    input logic [1:0]        arburst,
    input logic              rvalid,
    input logic              rready,
    input logic              rlast,
    input logic              done,
    input logic              err
);
    logic [DLY_W:0] since_rst;
    logic [OUT_W:0] in_flight;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_rst <= '0;
            in_flight <= '0;
        end else begin
            if (since_rst != {(DLY_W+1){1'b1}})
                since_rst <= since_rst + 1'b1;
            in_flight <= in_flight + (OUT_W+1)'(arvalid && arready)
                                   - (OUT_W+1)'(rvalid && rready && rlast);
        end
    end

    assert_req_hold_R3: assert property (@(posedge clk) disable iff (rst)
        arvalid && !arready |=> arvalid && $stable(araddr) && $stable(arlen));

    assert_req_format_R3: assert property (@(posedge clk) disable iff (rst)
        arvalid |-> arsize == 3'd6 && arburst == 2'b01 && araddr[5:0] == 6'd0);

    assert_page_bound_R5: assert property (@(posedge clk) disable iff (rst)
        arvalid |-> ({1'b0, araddr[11:0]} + ((13'(arlen) + 13'd1) << 6)) <= 13'd4096);

    assert_start_delay_R2: assert property (@(posedge clk) disable iff (rst)
        arvalid |-> since_rst > {1'b0, cfg_start_delay});

    assert_in_flight_R9: assert property (@(posedge clk) disable iff (rst)
        in_flight <= {1'b0, cfg_max_out});

    assert_done_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

    assert_done_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        done |-> !arvalid && in_flight == '0);

    assert_err_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        err |=> err);
endmodule

bind rdgen_top rdgen_chk #(
    .ADDR_W (ADDR_W),
    .DLY_W  (DLY_W),
    .OUT_W  (OUT_W)
) u_chk (
    .clk             (clk),
    .rst             (rst),
    .cfg_start_delay (cfg_start_delay),
    .cfg_max_out     (cfg_max_out),
    .arvalid         (arvalid),
    .arready         (arready),
    .araddr          (araddr),
    .arlen           (arlen),
    .arsize          (arsize),
    .arburst         (arburst),
    .rvalid          (rvalid),
    .rready          (rready),
    .rlast           (rlast),
    .done            (done),
    .err             (err)
);

// File: tb/rdgen_top_tb.sv
`timescale 1ns/1ps
module rdgen_top_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cfg_start_delay = '0;
    logic [31:0] cfg_total_bytes = '0;
    logic [5:0]  cfg_len = '0;
    logic [7:0]  cfg_gap = '0;
    logic [12:0] cfg_bw_inc = '0;
    logic [6:0]  cfg_w0 = '0;
    logic [31:0] cfg_base0 = 32'h1000_0000;
    logic [4:0]  cfg_k0 = 5'd16;
    logic [31:0] cfg_base1 = 32'h2000_0000;
    logic [4:0]  cfg_k1 = 5'd14;
    logic [2:0]  cfg_max_out = 3'd1;
    logic        arvalid, arready = 1'b0;
    logic [31:0] araddr;
    logic [7:0]  arlen;
    logic [2:0]  arsize;
    logic [1:0]  arburst;
    logic        rvalid = 1'b0, rready, rlast = 1'b0;
    logic [1:0]  rresp = 2'b00;
    logic        done, err;

    always #2.5 clk = ~clk;

    rdgen_top u_dut (
        .clk(clk), .rst(rst),
        .cfg_start_delay(cfg_start_delay), .cfg_total_bytes(cfg_total_bytes),
        .cfg_len(cfg_len), .cfg_gap(cfg_gap), .cfg_bw_inc(cfg_bw_inc),
        .cfg_w0(cfg_w0), .cfg_base0(cfg_base0), .cfg_k0(cfg_k0),
        .cfg_base1(cfg_base1), .cfg_k1(cfg_k1), .cfg_max_out(cfg_max_out),
        .arvalid(arvalid), .arready(arready), .araddr(araddr), .arlen(arlen),
        .arsize(arsize), .arburst(arburst), .rvalid(rvalid), .rready(rready),
        .rresp(rresp), .rlast(rlast), .done(done), .err(err)
    );

    int checks = 0;
    int errors = 0;

    // Per-run model state, cleared before each run.
    bit      mon_en = 1'b0;
    longint  cyc, cum_bytes, beats_rx;
    int      n_req, out_b, low_cnt, win0_n, win1_n, inj_beat;
    bit      prev_av, prev_hs, seen_hs, early_done, req_after_done;
    int      q_len [0:15];
    int      q_wr, q_rd, cur_left;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic longint exp_bytes(input longint total, input int len);
        longint bb = (len + 1) * 64;
        return ((total + bb - 1) / bb) * bb;
    endfunction

    function automatic bit in_win(input logic [31:0] a, input logic [31:0] b, input int k);
        return (a >= b) && ({32'd0, a} < {32'd0, b} + (64'd1 << k));
    endfunction

    // Slave model and monitor: decisions taken at the falling edge for the next rising edge.
    initial begin
        forever begin
            @(negedge clk);
            if (mon_en && !rst) begin
                bit hs;
                cyc++;
                // Read data channel first, so a request queued now is served later.
                if (cur_left == 0 && q_rd != q_wr) begin
                    cur_left = q_len[q_rd % 16] + 1;
                    q_rd++;
                end
                if (cur_left > 0 && ($urandom % 10) < 7) begin
                    rvalid = 1'b1;
                    rlast  = (cur_left == 1);
                    rresp  = (beats_rx == inj_beat) ? 2'b10 : 2'b00;
                    beats_rx++;
                    cur_left--;
                    if (rlast) out_b--;
                end else begin
                    rvalid = 1'b0;
                    rlast  = 1'b0;
                    rresp  = 2'b00;
                end
                // Read address channel.
                if (arvalid && (!prev_av || prev_hs)) begin
                    bit i0, i1;
                    longint nb;
                    nb = (longint'(arlen) + 1) * 64;
                    if (n_req == 0)
                        chk(cyc > cfg_start_delay, "R2", "first request cycle", cyc, cfg_start_delay + 1);
                    chk(arsize == 3'd6 && arburst == 2'b01 && araddr[5:0] == 0 && arlen == {2'b00, cfg_len},
                        "R3", "request format len", arlen, cfg_len);
                    chk({20'd0, araddr[11:0]} + nb <= 4096, "R5", "page end", araddr[11:0] + nb, 4096);
                    i0 = in_win(araddr, cfg_base0, cfg_k0);
                    i1 = in_win(araddr, cfg_base1, cfg_k1);
                    if (i0) win0_n++; else if (i1) win1_n++;
                    if (cfg_w0 == 100)     chk(i0, "R4", "weight 100 window0 addr", araddr, cfg_base0);
                    else if (cfg_w0 == 0)  chk(i1, "R4", "weight 0 window1 addr", araddr, cfg_base1);
                    else                   chk(i0 || i1, "R4", "addr inside a window", araddr, cfg_base0);
                    if (seen_hs)
                        chk(low_cnt >= cfg_gap, "R7", "idle cycles before request", low_cnt, cfg_gap);
                    if (done) req_after_done = 1'b1;
                    cum_bytes += nb;
                    chk(cum_bytes <= longint'(cfg_bw_inc) * cyc, "R8", "bytes vs credit", cum_bytes,
                        longint'(cfg_bw_inc) * cyc);
                    out_b++;
                    chk(out_b <= cfg_max_out, "R9", "bursts in flight", out_b, cfg_max_out);
                    n_req++;
                end
                arready = (($urandom % 4) != 0);
                hs = arvalid && arready;
                if (hs) begin
                    q_len[q_wr % 16] = int'(arlen);
                    q_wr++;
                    seen_hs = 1'b1;
                    low_cnt = 0;
                end else if (!arvalid) begin
                    low_cnt++;
                end
                if (done && (out_b != 0 || cum_bytes < exp_bytes(cfg_total_bytes, cfg_len)))
                    early_done = 1'b1;
                prev_av = arvalid;
                prev_hs = hs;
            end
        end
    end

    task automatic run_ep(input int dly, input longint tot, input int len, input int gap,
                          input int inc, input int w0, input int cap, input int k0,
                          input int k1, input int inj);
        longint exp;
        int     wd;
        @(negedge clk);
        mon_en = 1'b0;
        rst = 1'b1;
        arready = 1'b0; rvalid = 1'b0; rlast = 1'b0; rresp = 2'b00;
        cfg_start_delay = 16'(dly); cfg_total_bytes = 32'(tot); cfg_len = 6'(len);
        cfg_gap = 8'(gap); cfg_bw_inc = 13'(inc); cfg_w0 = 7'(w0);
        cfg_max_out = 3'(cap); cfg_k0 = 5'(k0); cfg_k1 = 5'(k1);
        repeat (4) @(negedge clk);
        chk(arvalid == 0 && done == 0 && err == 0 && rready == 1, "R1", "outputs in reset",
            {arvalid, done, err, rready}, 4'b0001);
        cyc = 0; cum_bytes = 0; beats_rx = 0; n_req = 0; out_b = 0; low_cnt = 0;
        win0_n = 0; win1_n = 0; inj_beat = inj; q_wr = 0; q_rd = 0; cur_left = 0;
        prev_av = 0; prev_hs = 0; seen_hs = 0; early_done = 0; req_after_done = 0;
        #1;
        rst = 1'b0;
        mon_en = 1'b1;
        @(negedge clk);
        #1;
        chk(arvalid == 0 && done == 0 && err == 0 && rready == 1, "R1", "outputs after release",
            {arvalid, done, err, rready}, 4'b0001);
        wd = 0;
        while (!done && wd < 40000) begin
            @(negedge clk);
            wd++;
        end
        chk(wd < 40000, "R10", "watchdog before done", wd, 40000);
        repeat (40) @(negedge clk);
        exp = exp_bytes(tot, len);
        chk(done == 1, "R10", "done stays high", done, 1);
        chk(!early_done, "R10", "done before completion", early_done, 0);
        chk(cum_bytes == exp, "R6", "bytes requested", cum_bytes, exp);
        chk(beats_rx == exp / 64, "R6", "beats returned", beats_rx, exp / 64);
        chk(!req_after_done && arvalid == 0, "R6", "request after budget", req_after_done, 0);
        chk(err == (inj >= 0 && inj < exp / 64), "R11", "error flag", err, inj >= 0 && inj < exp / 64);
        if (w0 > 0 && w0 < 100 && n_req >= 16) begin
            chk(win0_n > 0, "R4", "window0 used", win0_n, 1);
            chk(win1_n > 0, "R4", "window1 used", win1_n, 1);
        end
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd20240611);
        // Example profile: 40/60 split, 5120-byte budget, start delay.
        run_ep(100, 5120, 3, 2, 64, 40, 4, 16, 14, -1);
        // Budget not a multiple of the burst, single burst in flight, window 0 only.
        run_ep(0, 1000, 7, 0, 4096, 100, 1, 13, 12, -1);
        // Full-page bursts, window 1 only, slow credit, error mid burst.
        run_ep(5, 16384, 63, 7, 100, 0, 2, 12, 12, 70);
        // Zero budget: no traffic, done after the silent period.
        run_ep(20, 0, 3, 0, 256, 50, 4, 12, 12, -1);
        // Tight credit: one 1024-byte burst per 64 cycles.
        run_ep(3, 8192, 15, 0, 16, 70, 4, 15, 13, -1);
        // Constrained random profiles.
        for (int i = 0; i < 4; i++) begin
            int ln;
            ln = int'($urandom % 16);
            run_ep(int'($urandom % 200), longint'($urandom % (8 * (ln + 1) * 64)) + 1, ln,
                   int'($urandom % 11), 16 + int'($urandom % 2033), int'($urandom % 101),
                   1 + int'($urandom % 4), 12 + int'($urandom % 5), 12 + int'($urandom % 5),
                   (i == 2) ? 3 : -1);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule